// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block gathers eighteen level-sensitive interrupt request lines and turns them into one request towards a CPU. It also gives the CPU the index of the winning source. The sources are split into six groups. A programmable field assigns each group one of four priority levels, and all members of a group share that level. When several enabled requests are pending, the one at the highest level wins. If they share a level, the lowest source index wins.

The CPU takes a request with a one-cycle acknowledge strobe. That strobe latches the vector index and records the request's level as in service. The CPU ends a handler with a one-cycle return strobe, which retires the most recent in-service level. While a handler runs, only a request at a strictly higher level raises the CPU request again. This allows handlers to nest up to four deep.

A fixed subset of the sources can wake the device from sleep: by default the sources serving pin activity and the sleep timer. For these sources a combinational wake output is driven straight from the request lines, so it works while the core clock is stopped.

Top module: `grp_irq_ctrl`

## Requirements
- R1: After reset `irq_o` is 0, `vec_o` is 0 and no level is in service. The first enabled request at any level then raises `irq_o`.
- R2: Source s belongs to group g = s mod 6. Its level is `grp_prio_i[2g+1:2g]`, and a larger value is a higher priority (3 is highest).
- R3: Among eligible requests, the source at the highest level is the winner. On a tie in level, the lowest-numbered source wins.
- R4: A source whose `src_en_i` bit is 0 never raises `irq_o`, even with its request line high. While `glob_en_i` is 0, `irq_o` stays 0.
- R5: `irq_o` is 1 only when the winner's level is strictly above the highest level in service, or when nothing is in service.
- R6: An acknowledge while `irq_o` is 1 and `reti_i` is 0 has two effects. In the next cycle `vec_o` shows the winner's index, and the winner's level is in service. An acknowledge while `irq_o` is 0 has no effect.
- R7: A return strobe retires the highest level in service. With nothing in service it has no effect. When the return strobe and an acknowledge arrive in the same cycle, the acknowledge is ignored.
- R8: Handlers nest up to four deep, one per level, when levels 0, 1, 2 and 3 are taken in turn. Four returns then empty the in-service state.
- R9: `wake_o` is the combinational OR of `irq_req_i & src_en_i & WAKE_MASK`, where the default mask 18'h00027 covers sources 0, 1, 2 and 5. `wake_o` does not depend on `glob_en_i` or on the clock.
- R10: `vec_o` changes only on an accepted acknowledge. A return strobe leaves `vec_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req_i | input | 18 | Level-sensitive request line per source |
| src_en_i | input | 18 | Enable bit per source |
| glob_en_i | input | 1 | Global enable for the CPU request |
| grp_prio_i | input | 12 | Two-bit level per group; group g at bits [2g+1:2g] |
| ack_i | input | 1 | One-cycle acknowledge from the CPU |
| reti_i | input | 1 | One-cycle return-from-interrupt strobe |
| irq_o | output | 1 | Request to the CPU |
| vec_o | output | 5 | Index of the last acknowledged source |
| wake_o | output | 1 | Wake request to the power controller |

## Verification
The hardest state to reach is a full four-deep nest. Getting there needs a rising chain of group levels, with each acknowledge landing while a higher-level source is pending. It also needs a later lower-level request that must stay masked until the matching returns arrive. A directed sequence programs the groups to levels 0 through 3 and raises one source per group. It acknowledges each source in turn and then unwinds with returns, checking the request after every step. Random stimulus on top of this mixes ties inside a group, same-cycle return and acknowledge, and returns with nothing in service. A bench model of the in-service levels tracks all of it.

// File: rtl/grp_irq_pkg.sv
package grp_irq_pkg;
  function automatic int unsigned grp_of(int unsigned src, int unsigned ngrp);
    return src % ngrp;
  endfunction

  function automatic int unsigned fld_lsb(int unsigned grp, int unsigned lvlw);
    return grp * lvlw;
  endfunction
endpackage

// File: rtl/grp_irq_arb.sv
module grp_irq_arb
  import grp_irq_pkg::*;
#(
  parameter int NSRC = 18,
  parameter int NGRP = 6,
  parameter int LVLW = 2,
  parameter int IDXW = 5
) (
  input  logic [NSRC-1:0]      elig_i,
  input  logic [NGRP*LVLW-1:0] prio_i,
  output logic                 win_vld_o,
  output logic [IDXW-1:0]      win_idx_o,
  output logic [LVLW-1:0]      win_lvl_o
);
  logic [LVLW-1:0] src_lvl [NSRC];

  for (genvar s = 0; s < NSRC; s++) begin : g_lvl
    localparam int LSB = fld_lsb(grp_of(s, NGRP), LVLW);
    assign src_lvl[s] = prio_i[LSB +: LVLW];
  end

  always_comb begin
    win_vld_o = 1'b0;
    win_idx_o = '0;
    win_lvl_o = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (elig_i[s] && (!win_vld_o || src_lvl[s] > win_lvl_o)) begin
        win_vld_o = 1'b1;
        win_idx_o = IDXW'(s);
        win_lvl_o = src_lvl[s];
      end
    end
  end

  always_comb begin
    if (win_vld_o) begin
      a_r3_winner_eligible: assert (elig_i[win_idx_o]);
    end
  end
endmodule

// File: rtl/grp_irq_isr.sv
module grp_irq_isr #(
  parameter int LVLW = 2,
  localparam int NLVL = 2**LVLW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_i,
  input  logic [LVLW-1:0] push_lvl_i,
  input  logic            pop_i,
  output logic            busy_o,
  output logic [LVLW-1:0] top_lvl_o
);
  logic [NLVL-1:0] mask_q;

  always_comb begin
    top_lvl_o = '0;
    for (int i = 0; i < NLVL; i++) begin
      if (mask_q[i]) top_lvl_o = LVLW'(i);
    end
  end
  assign busy_o = |mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (pop_i) begin
      if (busy_o) mask_q[top_lvl_o] <= 1'b0;
    end else if (push_i) begin
      mask_q[push_lvl_i] <= 1'b1;
    end
  end

  a_r8_push_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i) |=> $countones(mask_q) == $past($countones(mask_q)) + 1);
  a_r7_pop_removes_one: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && busy_o) |=> $countones(mask_q) == $past($countones(mask_q)) - 1);
  a_r5_push_above_top: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && busy_o) |-> push_lvl_i > top_lvl_o);
endmodule

// File: rtl/grp_irq_wake.sv
module grp_irq_wake #(
  parameter int              NSRC      = 18,
  parameter logic [NSRC-1:0] WAKE_MASK = 18'h00027
) (
  input  logic [NSRC-1:0] req_i,
  input  logic [NSRC-1:0] en_i,
  output logic            wake_o
);
  logic [NSRC-1:0] wake_src;
  assign wake_src = req_i & en_i & WAKE_MASK;
  assign wake_o   = |wake_src;

  always_comb begin
    if (wake_o) begin
      a_r9_wake_needs_enabled: assert ((req_i & en_i) != '0);
    end
  end
endmodule

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl #(
  parameter int              NSRC      = 18,
  parameter int              NGRP      = 6,
  parameter int              LVLW      = 2,
  parameter logic [NSRC-1:0] WAKE_MASK = 18'h00027,
  localparam int             IDXW      = $clog2(NSRC)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSRC-1:0]      irq_req_i,
  input  logic [NSRC-1:0]      src_en_i,
  input  logic                 glob_en_i,
  input  logic [NGRP*LVLW-1:0] grp_prio_i,
  input  logic                 ack_i,
  input  logic                 reti_i,
  output logic                 irq_o,
  output logic [IDXW-1:0]      vec_o,
  output logic                 wake_o
);
  logic [NSRC-1:0] elig;
  logic            win_vld;
  logic [IDXW-1:0] win_idx;
  logic [LVLW-1:0] win_lvl;
  logic            isr_busy;
  logic [LVLW-1:0] isr_top;
  logic            take;

  assign elig = irq_req_i & src_en_i & {NSRC{glob_en_i}};

  grp_irq_arb #(.NSRC(NSRC), .NGRP(NGRP), .LVLW(LVLW), .IDXW(IDXW)) u_arb (
    .elig_i    (elig),
    .prio_i    (grp_prio_i),
    .win_vld_o (win_vld),
    .win_idx_o (win_idx),
    .win_lvl_o (win_lvl)
  );

  assign irq_o = win_vld && (!isr_busy || win_lvl > isr_top);
  assign take  = ack_i && irq_o && !reti_i;

  grp_irq_isr #(.LVLW(LVLW)) u_isr (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (take),
    .push_lvl_i (win_lvl),
    .pop_i      (reti_i),
    .busy_o     (isr_busy),
    .top_lvl_o  (isr_top)
  );

  grp_irq_wake #(.NSRC(NSRC), .WAKE_MASK(WAKE_MASK)) u_wake (
    .req_i  (irq_req_i),
    .en_i   (src_en_i),
    .wake_o (wake_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    vec_o <= '0;
    else if (take) vec_o <= win_idx;
  end

  a_r4_off_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en_i |-> !irq_o);
  a_r4_irq_src_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (src_en_i[win_idx] && irq_req_i[win_idx]));
  a_r6_vec_latched: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> vec_o == $past(win_idx));
  a_r10_vec_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(vec_o));
endmodule

// File: tb/grp_irq_ctrl_bench.sv
module grp_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [17:0] req = '0, en = '0;
  logic        glob = 1'b0;
  logic [11:0] prio = '0;
  logic        ack = 1'b0, reti = 1'b0;
  logic        irq, wake;
  logic [4:0]  vec;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [3:0] m_mask = '0;
  int         m_vec = 0;

  always #10 clk = ~clk;

  grp_irq_ctrl u_grp_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_req_i(req), .src_en_i(en),
    .glob_en_i(glob), .grp_prio_i(prio), .ack_i(ack), .reti_i(reti),
    .irq_o(irq), .vec_o(vec), .wake_o(wake)
  );

  function automatic int lvl_of(int s, logic [11:0] p);
    int g = s % 6;
    return int'(p[2*g +: 2]);
  endfunction

  function automatic int top_of(logic [3:0] m);
    int t = -1;
    for (int i = 0; i < 4; i++) if (m[i]) t = i;
    return t;
  endfunction

  task automatic winner(output bit v, output int idx, output int lvl);
    v = 0; idx = 0; lvl = -1;
    for (int s = 17; s >= 0; s--) begin
      if (req[s] && en[s] && glob && lvl_of(s, prio) >= lvl) begin
        v = 1; idx = s; lvl = lvl_of(s, prio);
      end
    end
  endtask

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(logic [17:0] r, logic [17:0] e, logic g, logic [11:0] p,
                      logic a, logic rt, string tag);
    bit v; int idx, lvl, t, exp_irq;
    @(negedge clk);
    req = r; en = e; glob = g; prio = p; ack = a; reti = rt;
    #2;
    winner(v, idx, lvl);
    t = top_of(m_mask);
    exp_irq = (v && lvl > t) ? 1 : 0;
    chk({tag, " irq"}, int'(irq), exp_irq);
    chk({tag, " R9 wake"}, int'(wake), int'(|(r & e & 18'h00027)));
    if (rt) begin
      if (t >= 0) m_mask[t] = 1'b0;
    end else if (a && exp_irq == 1) begin
      m_mask[lvl] = 1'b1;
      m_vec = idx;
    end
    @(posedge clk);
    #2;
    chk({tag, " vec"}, int'(vec), m_vec);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'd12345;
    void'($urandom(seed));
    #1;
    chk("R1 reset irq", int'(irq), 0);
    chk("R1 reset vec", int'(vec), 0);
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1: first request at level 0 raises irq
    step(18'h00008, '1, 1, 12'h000, 0, 0, "R1 first");
    // R4: disabled source and global off
    step(18'h00010, 18'h3ffef, 1, 12'hfff, 0, 0, "R4 src off");
    step(18'h3ffff, '1, 0, 12'hfff, 1, 0, "R4 glob off");
    chk("R6 ack ignored vec", int'(vec), 0);
    // R3 tie: sources 0 and 6 share group 0, lowest wins
    step(18'h00041, '1, 1, 12'h001, 1, 0, "R3 tie");
    chk("R3 tie vec", int'(vec), 0);
    step(18'h00000, '1, 1, 12'h001, 0, 1, "R7 ret");
    // R2: source 13 in group 1 at level 2 beats source 0 at level 1
    step(18'h02001, '1, 1, 12'h009, 1, 0, "R2 group");
    chk("R2 vec 13", int'(vec), 13);
    // R5: same-level source 1 must not preempt level 2
    step(18'h00002, '1, 1, 12'h009, 1, 0, "R5 no preempt");
    chk("R5 vec kept", int'(vec), 13);
    // R7: return and ack same cycle, ack ignored
    step(18'h00002, '1, 1, 12'h009, 1, 1, "R7 both");
    chk("R10 vec after ret", int'(vec), 13);
    step(18'h00000, '1, 1, 12'h009, 0, 1, "R7 empty ret");
    // R8: four-deep nesting, groups 0..3 at levels 0..3
    step(18'h00001, '1, 1, 12'h0e4, 1, 0, "R8 n0");
    step(18'h00003, '1, 1, 12'h0e4, 1, 0, "R8 n1");
    step(18'h00007, '1, 1, 12'h0e4, 1, 0, "R8 n2");
    step(18'h0000f, '1, 1, 12'h0e4, 1, 0, "R8 n3");
    chk("R8 deepest vec", int'(vec), 3);
    for (int k = 0; k < 4; k++) step(18'h00001, '1, 1, 12'h0e4, 0, 1, "R8 unwind");
    chk("R8 empty", int'(m_mask), 0);
    // R9: wake with glob off, and masked by enable
    step(18'h00020, '1, 0, 12'h000, 0, 0, "R9 glob off");
    step(18'h00020, 18'h3ffdf, 0, 12'h000, 0, 0, "R9 disabled");
    step(18'h00008, '1, 0, 12'h000, 0, 0, "R9 non wake");
    // random mix
    for (int k = 0; k < 600; k++) begin
      logic [17:0] r = 18'($urandom);
      logic [17:0] e = 18'($urandom) | 18'($urandom);
      logic g = ($urandom % 8) != 0;
      logic [11:0] p = 12'($urandom);
      logic a = ($urandom % 3) == 0;
      logic rt = ($urandom % 5) == 0;
      step(r, e, g, p, a, rt, "R3 R5 R6 random");
    end
    @(negedge clk);
    ack = 0; reti = 0;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule